// File: doc/BRIEF.md
# Keyed Watchdog with Pre-Warning Timer

This peripheral guards a system against stalled software. It holds two 16-bit down-counters that are driven by a common tick. The watchdog counter requests a system reset when it runs out. The pre-warning counter raises an interrupt at an earlier point, so that software has a chance to react before the reset. An external tick-enable input supplies the base rate. A prescaler divides that rate by 1, by DIV_MID or by DIV_SLOW. With the default divisors, a 32.768 kHz base rate becomes 32.768 kHz, 1.024 kHz or 32 Hz.

Software reaches the block over a simple byte-wide register bus. A write is a single-cycle strobe. A read is combinational on the address. Software restarts the watchdog only by writing one specific key byte. Per-register lock bits let boot code freeze the setup, so that misbehaving software cannot later change it. A separate stop path halts the watchdog, and it only works once stopping has been permitted.

Top module: `kwd_top`

## Requirements
- R1: After reset, these values hold: configuration (0x01) reads 0x00, prescaler select (0x02) reads 0x00, the live pre-warning count (0x40 low, 0x41 high) reads 0, the live watchdog count (0x60 low, 0x61 high) reads WD_INIT (default 0xFFFF), and both irq_o and rst_req_o are low.
- R2: The following registers read back the last accepted write: pre-warning load (0x03 high byte, 0x04 low byte), watchdog reload (0x06 low byte, 0x09 high byte), prescaler select (0x02, bits 1:0) and the stop-permit bit (bit 4 of control 0x05). The key register (0x07) always reads 0.
- R3: Prescaler select chooses the rate of the prescaled tick. Code 0 passes every base tick. Code 1 passes every DIV_MID-th tick. Codes 2 and 3 pass every DIV_SLOW-th tick. A write to 0x02 restarts the division.
- R4: The pre-warning counter decrements on each prescaled tick. On the tick that takes it from 1 to 0, irq_o goes high. The counter then stays at 0 and irq_o stays high until software reloads the counter.
- R5: Writing 1 to control bit 0 copies the pre-warning load value into the counter and clears irq_o. Control bits 0 and 5 always read as 0.
- R6: Writing 0x5C to 0x07 copies the watchdog reload value into the watchdog counter. This only happens while configuration bit 5 (key enable) is set. Any other value, or any write while key enable is clear, leaves the count unchanged.
- R7: Configuration bit 4 selects the watchdog tick. When the bit is 1, the watchdog uses the prescaled tick. When it is 0, the watchdog uses the raw base tick.
- R8: On the tick that takes the watchdog counter from 1 to 0, rst_req_o pulses high for exactly one cycle. The counter then holds at 0 until the next key reload.
- R9: A control write with bit 5 and bit 4 both set halts the watchdog counter. A write with bit 5 set but bit 4 clear does nothing. The counter resumes on a key reload, or on a control write that clears bit 4.
- R10: Each configuration lock bit blocks writes to one register group. Bit 3 guards the watchdog reload bytes. Bit 2 guards the pre-warning load bytes. Bit 1 guards the prescaler select. Bit 0 guards the configuration register itself. Once set, a lock bit stays set until reset, and blocked writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 7 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on the address |
| tick_i | input | 1 | Base-rate tick enable |
| irq_o | output | 1 | Pre-warning interrupt, level pending |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is an expired watchdog that is being held at zero. In that state the reset request must not repeat on later ticks, and a key write made while key enable is clear must not revive the counter. The stimulus reaches this state by first loading a small reload value through the key. It then walks the counter tick by tick to exactly 1 and then 0, and keeps ticking after that. Finally it turns key enable off and writes the key. The slowest prescaler rate is covered by driving the full DIV_SLOW base ticks and checking that the count has not changed on the tick just before the boundary.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] A_CFG  = 7'h01;
  localparam logic [ADDR_W-1:0] A_PSEL = 7'h02;
  localparam logic [ADDR_W-1:0] A_PWHI = 7'h03;
  localparam logic [ADDR_W-1:0] A_PWLO = 7'h04;
  localparam logic [ADDR_W-1:0] A_CTRL = 7'h05;
  localparam logic [ADDR_W-1:0] A_WDLO = 7'h06;
  localparam logic [ADDR_W-1:0] A_KEY  = 7'h07;
  localparam logic [ADDR_W-1:0] A_WDHI = 7'h09;
  localparam logic [ADDR_W-1:0] A_PWCL = 7'h40;
  localparam logic [ADDR_W-1:0] A_PWCH = 7'h41;
  localparam logic [ADDR_W-1:0] A_WDCL = 7'h60;
  localparam logic [ADDR_W-1:0] A_WDCH = 7'h61;

  localparam logic [7:0] KEY_BYTE = 8'h5C;

  // configuration bit positions
  localparam int CFG_KEYEN = 5;
  localparam int CFG_WDSRC = 4;
  localparam int CFG_LKWD  = 3;
  localparam int CFG_LKPW  = 2;
  localparam int CFG_LKPS  = 1;
  localparam int CFG_LKCFG = 0;

  // control bit positions
  localparam int CTL_PWRLD  = 0;
  localparam int CTL_PERMIT = 4;
  localparam int CTL_STOP   = 5;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2,
    RATE_SLW2 = 2'd3
  } rate_e;
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
  import kwd_pkg::*;
#(
  parameter int DIV_MID  = 32,
  parameter int DIV_SLOW = 1024
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  clr_i,
  input  rate_e rate_i,
  output logic  tick_o
);
  localparam int CW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    unique case (rate_i)
      RATE_FAST: limit = '0;
      RATE_MID:  limit = CW'(DIV_MID - 1);
      default:   limit = CW'(DIV_SLOW - 1);
    endcase
    tick_o = tick_i && (cnt_q == limit);
    cnt_d  = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kwd_downcnt.sv
module kwd_downcnt #(
  parameter int           W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step  = !load_i && run_i && tick_i && (cnt_q != '0);
    hit_o = step && (cnt_q == W'(1));
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int               DIV_MID  = 32,
  parameter int               DIV_SLOW = 1024,
  parameter logic [CNT_W-1:0] WD_INIT  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [5:0]       cfg_q, cfg_d;
  rate_e            psel_q, psel_d;
  logic [CNT_W-1:0] pw_ld_q, pw_ld_d, wd_ld_q, wd_ld_d;
  logic             permit_q, permit_d, wd_halt_q, halt_d;
  logic             pend_q, pend_d, rstreq_q;

  logic wr_cfg, wr_psel, wr_pwhi, wr_pwlo, wr_ctrl, wr_wdlo, wr_wdhi;
  logic wd_load, pw_load, pre_tick, wd_tick, pw_hit, wd_hit;
  logic [CNT_W-1:0] pw_cnt, wd_cnt;

  // write decode with lock gating
  always_comb begin
    wr_cfg  = bus_wr_i && (bus_addr_i == A_CFG)  && !cfg_q[CFG_LKCFG];
    wr_psel = bus_wr_i && (bus_addr_i == A_PSEL) && !cfg_q[CFG_LKPS];
    wr_pwhi = bus_wr_i && (bus_addr_i == A_PWHI) && !cfg_q[CFG_LKPW];
    wr_pwlo = bus_wr_i && (bus_addr_i == A_PWLO) && !cfg_q[CFG_LKPW];
    wr_wdhi = bus_wr_i && (bus_addr_i == A_WDHI) && !cfg_q[CFG_LKWD];
    wr_wdlo = bus_wr_i && (bus_addr_i == A_WDLO) && !cfg_q[CFG_LKWD];
    wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
    wd_load = bus_wr_i && (bus_addr_i == A_KEY) && (bus_wdata_i == KEY_BYTE)
              && cfg_q[CFG_KEYEN];
    pw_load = wr_ctrl && bus_wdata_i[CTL_PWRLD];
  end

  // next state
  always_comb begin
    cfg_d    = cfg_q;
    psel_d   = psel_q;
    pw_ld_d  = pw_ld_q;
    wd_ld_d  = wd_ld_q;
    permit_d = permit_q;
    halt_d   = wd_halt_q;
    pend_d   = pend_q;
    if (wr_cfg)  cfg_d = {bus_wdata_i[5:4], bus_wdata_i[3:0] | cfg_q[3:0]};
    if (wr_psel) psel_d = rate_e'(bus_wdata_i[1:0]);
    if (wr_pwhi) pw_ld_d[15:8] = bus_wdata_i;
    if (wr_pwlo) pw_ld_d[7:0]  = bus_wdata_i;
    if (wr_wdhi) wd_ld_d[15:8] = bus_wdata_i;
    if (wr_wdlo) wd_ld_d[7:0]  = bus_wdata_i;
    if (wr_ctrl) begin
      permit_d = bus_wdata_i[CTL_PERMIT];
      halt_d   = bus_wdata_i[CTL_PERMIT] &&
                 (bus_wdata_i[CTL_STOP] || wd_halt_q);
    end
    if (wd_load) halt_d = 1'b0;
    if (pw_load)     pend_d = 1'b0;
    else if (pw_hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q     <= '0;
      psel_q    <= RATE_FAST;
      pw_ld_q   <= '0;
      wd_ld_q   <= WD_INIT;
      permit_q  <= 1'b0;
      wd_halt_q <= 1'b0;
      pend_q    <= 1'b0;
      rstreq_q  <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      psel_q    <= psel_d;
      pw_ld_q   <= pw_ld_d;
      wd_ld_q   <= wd_ld_d;
      permit_q  <= permit_d;
      wd_halt_q <= halt_d;
      pend_q    <= pend_d;
      rstreq_q  <= wd_hit;
    end
  end

  kwd_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_psc (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .clr_i(wr_psel),
    .rate_i(psel_q), .tick_o(pre_tick)
  );

  assign wd_tick = cfg_q[CFG_WDSRC] ? pre_tick : tick_i;

  kwd_downcnt #(.W(CNT_W), .INIT('0)) u_pw (
    .clk(clk), .rst_n(rst_sync_n), .load_i(pw_load), .load_val_i(pw_ld_q),
    .tick_i(pre_tick), .run_i(1'b1), .cnt_o(pw_cnt), .hit_o(pw_hit)
  );

  kwd_downcnt #(.W(CNT_W), .INIT(WD_INIT)) u_wd (
    .clk(clk), .rst_n(rst_sync_n), .load_i(wd_load), .load_val_i(wd_ld_q),
    .tick_i(wd_tick), .run_i(!wd_halt_q), .cnt_o(wd_cnt), .hit_o(wd_hit)
  );

  // read mux
  always_comb begin
    unique case (bus_addr_i)
      A_CFG:   bus_rdata_o = {2'b00, cfg_q};
      A_PSEL:  bus_rdata_o = {6'd0, psel_q};
      A_PWHI:  bus_rdata_o = pw_ld_q[15:8];
      A_PWLO:  bus_rdata_o = pw_ld_q[7:0];
      A_CTRL:  bus_rdata_o = {3'b000, permit_q, 4'b0000};
      A_WDLO:  bus_rdata_o = wd_ld_q[7:0];
      A_WDHI:  bus_rdata_o = wd_ld_q[15:8];
      A_PWCL:  bus_rdata_o = pw_cnt[7:0];
      A_PWCH:  bus_rdata_o = pw_cnt[15:8];
      A_WDCL:  bus_rdata_o = wd_cnt[7:0];
      A_WDCH:  bus_rdata_o = wd_cnt[15:8];
      default: bus_rdata_o = 8'h00;
    endcase
  end

  assign irq_o     = pend_q;
  assign rst_req_o = rstreq_q;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req,
  input logic        irq,
  input logic [15:0] wd_cnt,
  input logic [15:0] pw_cnt,
  input logic        wd_load,
  input logic        pw_load,
  input logic        halted,
  input logic [3:0]  lock
);
  assert_rstreq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_rstreq_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (wd_cnt == 16'd0));

  assert_wd_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cnt == 16'd0 && !wd_load) |=> (wd_cnt == 16'd0));

  assert_irq_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pw_load) |=> irq);

  assert_irq_count_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pw_cnt == 16'd0));

  assert_reload_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pw_load |=> !irq);

  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wd_load) |=> $stable(wd_cnt));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lock) & ~lock) == 4'b0000));
endmodule

bind kwd_top kwd_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rst_req(rst_req_o), .irq(irq_o),
  .wd_cnt(wd_cnt), .pw_cnt(pw_cnt), .wd_load(wd_load), .pw_load(pw_load),
  .halted(wd_halt_q), .lock(cfg_q[3:0])
);

// File: tb/tb_kwd_top.sv
module tb_kwd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       irq, rst_req;

  int errors = 0;
  int checks = 0;
  int rq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  kwd_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tick_i(tick),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req) rq_cnt++;

  // read flag [15], address [14:8], data or expected value [7:0]
  localparam logic [15:0] VEC [18] = '{
    {1'b0, 7'h03, 8'h12}, {1'b0, 7'h04, 8'h34},
    {1'b1, 7'h03, 8'h12}, {1'b1, 7'h04, 8'h34},
    {1'b0, 7'h06, 8'h78}, {1'b0, 7'h09, 8'h56},
    {1'b1, 7'h06, 8'h78}, {1'b1, 7'h09, 8'h56},
    {1'b0, 7'h02, 8'h01}, {1'b1, 7'h02, 8'h01},
    {1'b0, 7'h02, 8'h00}, {1'b1, 7'h02, 8'h00},
    {1'b0, 7'h07, 8'hA5}, {1'b1, 7'h07, 8'h00},
    {1'b0, 7'h05, 8'h10}, {1'b1, 7'h05, 8'h10},
    {1'b0, 7'h05, 8'h00}, {1'b1, 7'h05, 8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, {8'h00, bus_rdata}, {8'h00, exp});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1 cfg", 7'h01, 8'h00);
    rd("R1 psel", 7'h02, 8'h00);
    rd("R1 pwcnt lo", 7'h40, 8'h00);
    rd("R1 pwcnt hi", 7'h41, 8'h00);
    rd("R1 wdcnt lo", 7'h60, 8'hFF);
    rd("R1 wdcnt hi", 7'h61, 8'hFF);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rst_req", {15'd0, rst_req}, 16'd0);

    // R2 register access table
    foreach (VEC[i]) begin
      if (VEC[i][15]) rd("R2 table", VEC[i][14:8], VEC[i][7:0]);
      else            wr(VEC[i][14:8], VEC[i][7:0]);
    end

    // R6 / R8 key reload and expiry on the raw tick
    wr(7'h01, 8'h20);
    wr(7'h06, 8'h05); wr(7'h09, 8'h00);
    wr(7'h07, 8'h5C);
    rd("R6 key reload", 7'h60, 8'h05);
    ticks(3);
    rd("R6 count down", 7'h60, 8'h02);
    wr(7'h07, 8'h5D);
    rd("R6 wrong key ignored", 7'h60, 8'h02);
    wr(7'h07, 8'h5C);
    rd("R6 key again", 7'h60, 8'h05);
    base = rq_cnt;
    ticks(4);
    rd("R8 at one", 7'h60, 8'h01);
    check("R8 no early request", rq_cnt[15:0], base[15:0]);
    ticks(1);
    rd("R8 at zero", 7'h60, 8'h00);
    check("R8 one pulse", rq_cnt[15:0], base[15:0] + 16'd1);
    ticks(3);
    rd("R8 held zero", 7'h60, 8'h00);
    check("R8 no repeat", rq_cnt[15:0], base[15:0] + 16'd1);
    wr(7'h01, 8'h00);
    wr(7'h07, 8'h5C);
    rd("R6 key disabled", 7'h60, 8'h00);
    wr(7'h01, 8'h20);
    wr(7'h07, 8'h5C);
    rd("R6 key enabled", 7'h60, 8'h05);

    // R7 / R3 prescaled watchdog source
    wr(7'h01, 8'h30);
    wr(7'h02, 8'h01);
    wr(7'h07, 8'h5C);
    ticks(31);
    rd("R3 mid rate before", 7'h60, 8'h05);
    ticks(1);
    rd("R7 prescaled step", 7'h60, 8'h04);
    wr(7'h02, 8'h02);
    wr(7'h07, 8'h5C);
    ticks(1023);
    rd("R3 slow rate before", 7'h60, 8'h05);
    ticks(1);
    rd("R3 slow rate step", 7'h60, 8'h04);
    wr(7'h02, 8'h00);
    wr(7'h07, 8'h5C);
    ticks(1);
    rd("R3 fast rate step", 7'h60, 8'h04);

    // R4 / R5 pre-warning counter
    wr(7'h06, 8'hFF); wr(7'h09, 8'hFF);
    wr(7'h07, 8'h5C);
    wr(7'h03, 8'h00); wr(7'h04, 8'h03);
    wr(7'h05, 8'h01);
    rd("R5 reload value", 7'h40, 8'h03);
    ticks(2);
    rd("R4 count", 7'h40, 8'h01);
    check("R4 irq low", {15'd0, irq}, 16'd0);
    ticks(1);
    rd("R4 zero", 7'h40, 8'h00);
    check("R4 irq raised", {15'd0, irq}, 16'd1);
    ticks(2);
    rd("R4 held zero", 7'h40, 8'h00);
    check("R4 irq held", {15'd0, irq}, 16'd1);
    wr(7'h05, 8'h01);
    check("R5 irq cleared", {15'd0, irq}, 16'd0);
    rd("R5 reloaded", 7'h40, 8'h03);
    rd("R5 ctrl reads", 7'h05, 8'h00);

    // R9 stop control
    wr(7'h06, 8'h10); wr(7'h09, 8'h00);
    wr(7'h07, 8'h5C);
    wr(7'h05, 8'h20);
    ticks(2);
    rd("R9 stop needs permit", 7'h60, 8'h0E);
    wr(7'h05, 8'h30);
    ticks(3);
    rd("R9 halted", 7'h60, 8'h0E);
    rd("R9 stop bit reads 0", 7'h05, 8'h10);
    wr(7'h07, 8'h5C);
    ticks(1);
    rd("R9 resumed by key", 7'h60, 8'h0F);
    wr(7'h05, 8'h00);

    // R10 locks
    wr(7'h01, 8'h28);
    wr(7'h01, 8'h20);
    rd("R10 lock sticky", 7'h01, 8'h28);
    wr(7'h01, 8'h2F);
    wr(7'h04, 8'h99);
    rd("R10 pw load locked", 7'h04, 8'h03);
    wr(7'h06, 8'h99);
    rd("R10 wd reload locked", 7'h06, 8'h10);
    wr(7'h02, 8'h02);
    rd("R10 psel locked", 7'h02, 8'h00);
    wr(7'h01, 8'h00);
    rd("R10 cfg locked", 7'h01, 8'h2F);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule